// File: doc/BRIEF.md
# Trigger-Stopped Circular Acquisition Controller

This block sequences a multi-channel circular sample store. A start-acquisition command clears the column pointer and begins writing. The pointer then advances once per pilot clock and wraps around the store for as long as no trigger arrives. When a trigger is accepted, the block notes how far the pointer was from the last column. Writing goes on for a programmed number of pilot clocks, and then the store freezes. The frozen pointer shows where the last write happened.

After the freeze, a validation window set by a latency value runs before the capture is declared complete. During that window further triggers are inhibited. At completion the busy output drops and an interrupt flag rises. The host clears the flag with a clear strobe, or by issuing the next start command. The analog array, the conversion and the host bus decode lie outside this block. The pointer is modelled as a digital counter.

Top module: `acq_stop_ctrl`

## Requirements
- R1: After reset the block is idle. `col_ptr_o`=0, `busy_o`=0, `irq_o`=0 and `trig_rec_o`=0.
- R2: `start_i` while idle or done moves the block to the armed state at the next clock edge. At that edge `busy_o` goes to 1, `col_ptr_o` is cleared to 0 and `irq_o` is cleared. `start_i` in any other state is ignored.
- R3: `col_ptr_o` advances by one on every clock while armed or in the post-trigger delay, wrapping from NCOL-1 (127) to 0. It holds its value in every other state.
- R4: A trigger accepted while armed loads `trig_rec_o` with NCOL minus c, where c is the `col_ptr_o` value in the trigger cycle. The result lies in the range 1..128.
- R5: With D' = `post_dly_i`, or 1 when `post_dly_i` is 0, the pointer advances D'+1 times counting from the trigger edge and then freezes at (c+D'+1) mod NCOL. `post_dly_i` is sampled at the trigger edge.
- R6: After the freeze, the validation window lasts `lat_i`+1 clocks, with `lat_i` sampled at the freeze. The block then enters done, and `busy_o` falls at that edge.
- R7: A trigger that arrives outside the armed state is ignored. `trig_rec_o`, `col_ptr_o` and the capture timing are unchanged.
- R8: `irq_o` is set at the edge that enters done. It is cleared by `irq_clr_i` or by an accepted start. A completion in the same cycle as `irq_clr_i` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pilot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-acquisition command strobe |
| trig_i | input | 1 | Trigger input |
| post_dly_i | input | DLY_W | Post-trigger delay in pilot clocks (0 acts as 1) |
| lat_i | input | LAT_W | Post-stop validation latency |
| irq_clr_i | input | 1 | Host clear of the interrupt flag |
| col_ptr_o | output | COL_W | Column write pointer |
| trig_rec_o | output | REC_W | Distance from trigger column to the last column |
| irq_o | output | 1 | Capture-complete interrupt flag |
| busy_o | output | 1 | High from accepted start until done |

## Verification
The embedded assertions check several properties on every cycle:
- the pointer holds when it is not advancing, and wraps at the last column;
- the timer reloads correctly;
- the trigger record changes only on an accepted trigger;
- a finished latency window leads to the done state with the interrupt raised;
- an interrupt clear takes effect;
- an accepted start raises busy.

Only the directed scenarios can show the absolute arithmetic. That covers the recorded distance, the frozen pointer after a wrapped delay, a zero delay treated as one, and the exact clock on which busy falls for a given latency. They also show that triggers and starts arriving mid-capture leave the result unchanged.

// File: rtl/acq_pkg.sv
package acq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ARMED = 3'd1,
      ST_POST  = 3'd2,
      ST_LAT   = 3'd3,
      ST_DONE  = 3'd4
   } acq_state_t;
endpackage

// File: rtl/acq_col_ptr.sv
module acq_col_ptr #(
   parameter int NCOL  = 128,
   parameter int COL_W = $clog2(NCOL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   output logic [COL_W-1:0] col_o
);
   localparam logic [COL_W-1:0] LAST = COL_W'(NCOL - 1);
   localparam bit POW2 = ((1 << COL_W) == NCOL);

   logic [COL_W-1:0] col_nxt;

   generate
      if (POW2) begin : g_natural_wrap
         assign col_nxt = col_o + 1'b1;
      end else begin : g_compare_wrap
         assign col_nxt = (col_o == LAST) ? '0 : col_o + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     col_o <= '0;
      else if (clr_i) col_o <= '0;
      else if (adv_i) col_o <= col_nxt;
   end

   AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !adv_i) |=> $stable(col_o)); // R3
   AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && adv_i && col_o == LAST) |=> (col_o == '0)); // R3
endmodule

// File: rtl/acq_timer.sv
module acq_timer #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic         zero_o
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (load_i)               cnt <= load_val_i;
      else if (dec_i && cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign zero_o = (cnt == '0);

   AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt == $past(load_val_i))); // R5
   AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !dec_i) |=> $stable(cnt)); // R6
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
   import acq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       trig_i,
   input  logic       tmr_zero_i,
   output acq_state_t state_o,
   output logic       start_ok_o,
   output logic       accept_o,
   output logic       freeze_o,
   output logic       finish_o
);
   acq_state_t state_nxt;

   assign start_ok_o = start_i && (state_o == ST_IDLE || state_o == ST_DONE);
   assign accept_o   = trig_i && (state_o == ST_ARMED);
   assign freeze_o   = tmr_zero_i && (state_o == ST_POST);
   assign finish_o   = tmr_zero_i && (state_o == ST_LAT);

   always_comb begin
      state_nxt = state_o;
      unique case (state_o)
         ST_IDLE, ST_DONE: if (start_ok_o) state_nxt = ST_ARMED;
         ST_ARMED:         if (accept_o)   state_nxt = ST_POST;
         ST_POST:          if (freeze_o)   state_nxt = ST_LAT;
         ST_LAT:           if (finish_o)   state_nxt = ST_DONE;
         default:                          state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_o <= ST_IDLE;
      else        state_o <= state_nxt;
   end

   AST_LAT_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == ST_LAT && tmr_zero_i) |=> (state_o == ST_DONE)); // R6
   AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && state_o == ST_DONE) |=> (state_o == ST_ARMED)); // R2
endmodule

// File: rtl/acq_stop_ctrl.sv
module acq_stop_ctrl
   import acq_pkg::*;
#(
   parameter int NCOL  = 128,
   parameter int DLY_W = 8,
   parameter int LAT_W = 8,
   parameter int REC_W = 8,
   parameter int COL_W = $clog2(NCOL)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             trig_i,
   input  logic [DLY_W-1:0] post_dly_i,
   input  logic [LAT_W-1:0] lat_i,
   input  logic             irq_clr_i,
   output logic [COL_W-1:0] col_ptr_o,
   output logic [REC_W-1:0] trig_rec_o,
   output logic             irq_o,
   output logic             busy_o
);
   localparam int TW = (DLY_W > LAT_W) ? DLY_W : LAT_W;
   localparam logic [REC_W-1:0] NCOL_R = REC_W'(NCOL);

   initial begin
      assert (NCOL >= 2) else $error("NCOL must be at least 2");
      assert (REC_W > COL_W && NCOL < (1 << REC_W))
         else $error("REC_W too narrow for NCOL");
   end

   acq_state_t       state;
   logic             start_ok, accept, freeze, finish, tmr_zero;
   logic [TW-1:0]    tmr_val;
   logic [DLY_W-1:0] dly_m1;

   acq_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .trig_i     (trig_i),
      .tmr_zero_i (tmr_zero),
      .state_o    (state),
      .start_ok_o (start_ok),
      .accept_o   (accept),
      .freeze_o   (freeze),
      .finish_o   (finish)
   );

   assign dly_m1  = (post_dly_i == '0) ? '0 : post_dly_i - 1'b1;
   assign tmr_val = accept ? TW'(dly_m1) : TW'(lat_i);

   acq_timer #(.W(TW)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept || freeze),
      .load_val_i (tmr_val),
      .dec_i      (state == ST_POST || state == ST_LAT),
      .zero_o     (tmr_zero)
   );

   acq_col_ptr #(.NCOL(NCOL), .COL_W(COL_W)) u_col (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (start_ok),
      .adv_i (state == ST_ARMED || state == ST_POST),
      .col_o (col_ptr_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      trig_rec_o <= '0;
      else if (accept) trig_rec_o <= NCOL_R - REC_W'(col_ptr_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      irq_o <= 1'b0;
      else if (finish)                 irq_o <= 1'b1;
      else if (start_ok || irq_clr_i)  irq_o <= 1'b0;
   end

   assign busy_o = (state == ST_ARMED) || (state == ST_POST) || (state == ST_LAT);

   AST_REC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(trig_i && state == ST_ARMED) |=> $stable(trig_rec_o)); // R7
   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LAT && tmr_zero) |=> irq_o); // R8
   AST_IRQ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr_i && state != ST_LAT) |=> !irq_o); // R8
   AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> busy_o); // R2
endmodule

// File: tb/test_acq_stop_ctrl.sv
`timescale 1ns/1ps
module test_acq_stop_ctrl;
   logic       clk = 1'b0;
   logic       rst_n, start, trig, irq_clr;
   logic [7:0] post_dly, lat;
   logic [6:0] col;
   logic [7:0] trig_rec;
   logic       irq, busy;
   int         n_chk = 0, n_fail = 0;
   bit         finished = 1'b0;

   always #2.5 clk = ~clk;

   acq_stop_ctrl i_acq_stop_ctrl (
      .clk(clk), .rst_n(rst_n), .start_i(start), .trig_i(trig),
      .post_dly_i(post_dly), .lat_i(lat), .irq_clr_i(irq_clr),
      .col_ptr_o(col), .trig_rec_o(trig_rec), .irq_o(irq), .busy_o(busy)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk("R1 col after reset", int'(col), 0);
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 irq after reset", int'(irq), 0);
      chk("R1 trig_rec after reset", int'(trig_rec), 0);
      trig = 1'b1; tick(1); trig = 1'b0;
      chk("R7 idle trigger trig_rec", int'(trig_rec), 0);
      chk("R7 idle trigger busy", int'(busy), 0);
      chk("R3 idle col holds", int'(col), 0);
   endtask

   // c: pointer at trigger, d: post delay, l: latency, noisy: extra trig/start mid-delay
   task automatic t_capture(int c, int d, int l, bit noisy);
      int dp = (d == 0) ? 1 : d;
      post_dly = 8'(d); lat = 8'(l);
      start = 1'b1; tick(1); start = 1'b0;
      chk("R2 busy after start", int'(busy), 1);
      chk("R2 col cleared", int'(col), 0);
      chk("R2 irq cleared by start", int'(irq), 0);
      tick(c);
      chk("R3 col advancing", int'(col), c % 128);
      trig = 1'b1; tick(1); trig = 1'b0;
      chk("R4 trig_rec", int'(trig_rec), 128 - c);
      if (noisy && dp >= 2) begin
         post_dly = 8'd3; trig = 1'b1; start = 1'b1;
         tick(1);
         trig = 1'b0; start = 1'b0;
         chk("R7 trigger in delay ignored", int'(trig_rec), 128 - c);
         tick(dp - 1);
      end else begin
         tick(dp);
      end
      chk("R5 frozen col", int'(col), (c + dp + 1) % 128);
      chk("R5 busy at freeze", int'(busy), 1);
      tick(l);
      chk("R6 busy in window", int'(busy), 1);
      chk("R8 irq low in window", int'(irq), 0);
      chk("R3 col held in window", int'(col), (c + dp + 1) % 128);
      tick(1);
      chk("R6 busy low at done", int'(busy), 0);
      chk("R8 irq at done", int'(irq), 1);
      chk("R5 col held at done", int'(col), (c + dp + 1) % 128);
   endtask

   task automatic t_done_ignore;
      int c0 = int'(col), r0 = int'(trig_rec);
      trig = 1'b1; tick(2); trig = 1'b0;
      chk("R7 done trigger trig_rec", int'(trig_rec), r0);
      chk("R7 done trigger col", int'(col), c0);
      chk("R7 done trigger busy", int'(busy), 0);
      chk("R8 irq holds in done", int'(irq), 1);
      irq_clr = 1'b1; tick(1); irq_clr = 1'b0;
      chk("R8 irq cleared by host", int'(irq), 0);
      chk("R8 clear leaves col", int'(col), c0);
   endtask

   initial begin
      rst_n = 1'b0; start = 1'b0; trig = 1'b0; irq_clr = 1'b0;
      post_dly = '0; lat = '0;
      @(negedge clk);
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_capture(5, 3, 2, 1'b0);
      t_done_ignore();
      t_capture(120, 20, 0, 1'b1);
      t_capture(0, 0, 4, 1'b0);
      t_capture(127, 200, 255, 1'b1);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule